// File: doc/BRIEF.md
# Byte-wide RAM size probe

This block measures how much RAM answers on a byte-wide memory bus. After a one-cycle start pulse it drives a sequence of single reads and writes through a plain strobe-and-ready port. It first makes sure something holds a byte at the lowest address. It then marks that address and probes power-of-two addresses in rising order until a probe shows that the address wrapped onto location zero or that nothing answered there. The address where the walk stopped is reported as the size.

The probe leaves memory as it found it. Every address that passes the walk gets its saved byte back, and the byte at address zero is rewritten at the end. Bus ownership is arranged by surrounding logic before start is pulsed. The upper bound of the walk is a power of two set by a parameter.

Top module: `ram_size_probe`

## Requirements
- R1: Out of reset `done` is low and neither `mem_rd` nor `mem_wr` is asserted.
- R2: An access keeps its strobe, `mem_addr` and (for writes) `mem_wdata` unchanged until a cycle with `mem_ready` high, ends at that edge, and `mem_rd` and `mem_wr` are never high together.
- R3: The probe reads address 0 and then address 1. It writes the inverse of the first byte to address 0 and the second byte back to address 1, then reads address 0. If that read is not exactly the inverse, the result is 0 and the run takes 6 accesses in total.
- R4: After a passing presence test the probe writes 0x55 to address 0 and visits addresses 1, 2, 4, ... while they are below 2^ADDR_W. At each one it saves the byte, writes 0xAA there, reads address 0, and reads the address back only if address 0 still holds 0x55. A passing address takes 5 accesses.
- R5: The result is the first visited address where address 0 no longer reads 0x55 or the address does not read 0xAA. It is 2^ADDR_W when no address fails.
- R6: Each passing address gets its saved byte back, and a final write puts the original byte back at address 0, so that all present memory holds its starting contents when `done` rises.
- R7: `done` stays high, with `size` unchanged and no strobe, until the next start pulse. `done` falls in the cycle after that pulse.
- R8: A start pulse while a run is in progress has no effect on the access sequence or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a probe |
| done | output | 1 | High once a probe has finished, until the next start |
| size | output | ADDR_W+1 | Detected size in bytes |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 8 | Read data, sampled in the ready cycle |
| mem_ready | input | 1 | Access completes in this cycle |

## Verification
The bench targets memories that alias above their real size, memories that float to 0xFF above it, a bus with nothing on it, a one-byte memory and a memory that fills the whole range. A probe that misses aliasing reports too large a size. One that treats the 0xFF floating bus as present never stops at the right address. One that skips a restore leaves a corrupted byte behind, and the bench catches this by comparing all present memory after the run. The bench also counts accesses, so an extra or missing access shows up. It stretches the ready latency to catch strobes that do not hold, and it pulses start during a run and again after done to check that the first is ignored and the second restarts the probe.

// File: rtl/rprobe_pkg.sv
package rprobe_pkg;

   localparam logic [7:0] MARK_BYTE = 8'h55;
   localparam logic [7:0] TAG_BYTE  = 8'hAA;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_RD_ZERO,
      PS_RD_ONE,
      PS_INV_ZERO,
      PS_KEEP_ONE,
      PS_CHK_ZERO,
      PS_MARK_ZERO,
      PS_STEP,
      PS_SAVE_AT,
      PS_TAG_AT,
      PS_VER_ZERO,
      PS_VER_AT,
      PS_PUT_AT,
      PS_FIX_ZERO,
      PS_DONE
   } probe_st_e;

endpackage

// File: rtl/rprobe_port.sv
module rprobe_port #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_go,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_wdata,
   output logic              ack,
   output logic [7:0]        rdata_q,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ready
);

   logic active;
   assign active = mem_rd | mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rd    <= 1'b0;
         mem_wr    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         ack       <= 1'b0;
         rdata_q   <= '0;
      end else begin
         ack <= 1'b0;
         if (active) begin
            if (mem_ready) begin
               mem_rd <= 1'b0;
               mem_wr <= 1'b0;
               ack    <= 1'b1;
               if (mem_rd) begin
                  rdata_q <= mem_rdata;
               end
            end
         end else if (req_go) begin
            mem_rd    <= ~req_wr;
            mem_wr    <= req_wr;
            mem_addr  <= req_addr;
            mem_wdata <= req_wdata;
         end
      end
   end

endmodule

// File: rtl/rprobe_walk.sv
module rprobe_walk #(
   parameter int ADDR_W = 19
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            step,
   output logic [ADDR_W:0] walk_addr,
   output logic            walk_end
);

   localparam int WALK_W = ADDR_W + 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_width
         $error("rprobe_walk: ADDR_W must lie in 2..30");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         walk_addr <= WALK_W'(1);
      end else if (clr) begin
         walk_addr <= WALK_W'(1);
      end else if (step) begin
         walk_addr <= {walk_addr[ADDR_W-1:0], 1'b0};
      end
   end

   assign walk_end = walk_addr[ADDR_W];

endmodule

// File: rtl/rprobe_ctrl.sv
module rprobe_ctrl
   import rprobe_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ack,
   input  logic [7:0]        rdata_q,
   input  logic [ADDR_W:0]   walk_addr,
   input  logic              walk_end,
   output logic              walk_clr,
   output logic              walk_step,
   output logic              req_go,
   output logic              req_wr,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_wdata,
   output logic              done,
   output logic [ADDR_W:0]   size
);

   localparam int SZ_W = ADDR_W + 1;
   localparam logic [SZ_W-1:0] FULL_SIZE = SZ_W'(1) << ADDR_W;

   probe_st_e state;
   logic      pend;
   logic      is_acc;
   logic [7:0] save_zero, save_one, save_at;
   logic      launch;

   assign launch    = start && (state == PS_IDLE || state == PS_DONE);
   assign walk_clr  = launch;
   assign walk_step = (state == PS_PUT_AT) && ack;
   assign done      = (state == PS_DONE);
   assign req_go    = is_acc && !pend;

   always_comb begin
      is_acc    = 1'b0;
      req_wr    = 1'b0;
      req_addr  = '0;
      req_wdata = '0;
      case (state)
         PS_RD_ZERO:   is_acc = 1'b1;
         PS_RD_ONE: begin
            is_acc   = 1'b1;
            req_addr = ADDR_W'(1);
         end
         PS_INV_ZERO: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_wdata = ~save_zero;
         end
         PS_KEEP_ONE: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_addr  = ADDR_W'(1);
            req_wdata = save_one;
         end
         PS_CHK_ZERO:  is_acc = 1'b1;
         PS_MARK_ZERO: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_wdata = MARK_BYTE;
         end
         PS_SAVE_AT: begin
            is_acc   = 1'b1;
            req_addr = walk_addr[ADDR_W-1:0];
         end
         PS_TAG_AT: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_addr  = walk_addr[ADDR_W-1:0];
            req_wdata = TAG_BYTE;
         end
         PS_VER_ZERO:  is_acc = 1'b1;
         PS_VER_AT: begin
            is_acc   = 1'b1;
            req_addr = walk_addr[ADDR_W-1:0];
         end
         PS_PUT_AT: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_addr  = walk_addr[ADDR_W-1:0];
            req_wdata = save_at;
         end
         PS_FIX_ZERO: begin
            is_acc    = 1'b1;
            req_wr    = 1'b1;
            req_wdata = save_zero;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PS_IDLE;
         pend      <= 1'b0;
         save_zero <= '0;
         save_one  <= '0;
         save_at   <= '0;
         size      <= '0;
      end else begin
         if (ack) begin
            pend <= 1'b0;
         end else if (req_go) begin
            pend <= 1'b1;
         end
         case (state)
            PS_IDLE, PS_DONE: begin
               if (launch) state <= PS_RD_ZERO;
            end
            PS_RD_ZERO: if (ack) begin
               save_zero <= rdata_q;
               state     <= PS_RD_ONE;
            end
            PS_RD_ONE: if (ack) begin
               save_one <= rdata_q;
               state    <= PS_INV_ZERO;
            end
            PS_INV_ZERO:  if (ack) state <= PS_KEEP_ONE;
            PS_KEEP_ONE:  if (ack) state <= PS_CHK_ZERO;
            PS_CHK_ZERO: if (ack) begin
               if (rdata_q != ~save_zero) begin
                  size  <= '0;
                  state <= PS_FIX_ZERO;
               end else begin
                  state <= PS_MARK_ZERO;
               end
            end
            PS_MARK_ZERO: if (ack) state <= PS_STEP;
            PS_STEP: begin
               if (walk_end) begin
                  size  <= FULL_SIZE;
                  state <= PS_FIX_ZERO;
               end else begin
                  state <= PS_SAVE_AT;
               end
            end
            PS_SAVE_AT: if (ack) begin
               save_at <= rdata_q;
               state   <= PS_TAG_AT;
            end
            PS_TAG_AT: if (ack) state <= PS_VER_ZERO;
            PS_VER_ZERO: if (ack) begin
               if (rdata_q != MARK_BYTE) begin
                  size  <= walk_addr;
                  state <= PS_FIX_ZERO;
               end else begin
                  state <= PS_VER_AT;
               end
            end
            PS_VER_AT: if (ack) begin
               if (rdata_q != TAG_BYTE) begin
                  size  <= walk_addr;
                  state <= PS_FIX_ZERO;
               end else begin
                  state <= PS_PUT_AT;
               end
            end
            PS_PUT_AT:   if (ack) state <= PS_STEP;
            PS_FIX_ZERO: if (ack) state <= PS_DONE;
            default:     state <= PS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ram_size_probe.sv
module ram_size_probe #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   output logic [ADDR_W:0]   size,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ready
);

   logic              req_go, req_wr, ack, walk_clr, walk_step, walk_end;
   logic [ADDR_W-1:0] req_addr;
   logic [7:0]        req_wdata, rdata_q;
   logic [ADDR_W:0]   walk_addr;

   rprobe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .rdata_q(rdata_q),
      .walk_addr(walk_addr), .walk_end(walk_end), .walk_clr(walk_clr),
      .walk_step(walk_step), .req_go(req_go), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .size(size)
   );

   rprobe_walk #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .clr(walk_clr), .step(walk_step),
      .walk_addr(walk_addr), .walk_end(walk_end)
   );

   rprobe_port #(.ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata_q(rdata_q),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

endmodule

// File: rtl/ram_size_probe_chk.sv
module ram_size_probe_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              done,
   input logic [ADDR_W:0]   size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              mem_ready
);

   localparam logic [ADDR_W:0] TOP = (ADDR_W+1)'(1) << ADDR_W;

   // R2: one strobe at a time
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R2: a read waits for ready with its address held
   a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

   // R2: a write waits for ready with address and data held
   a_r2_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

   // R7: result held until the next start
   a_r7_done_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(size)));

   // R7: bus quiet while done
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_rd && !mem_wr));

   // R5: result never beyond the walk limit
   a_r5_size_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (size <= TOP));

endmodule

bind ram_size_probe ram_size_probe_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .size(size),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
   .mem_wr(mem_wr), .mem_ready(mem_ready)
);

// File: tb/tb_ram_size_probe.sv
module tb_ram_size_probe;

   localparam int AW   = 10;
   localparam int MAXV = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          done;
   logic [AW:0]   size;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata, mem_rdata;
   logic          mem_rd, mem_wr, mem_ready;

   always #5 clk = ~clk;

   ram_size_probe #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done), .size(size),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   // memory model
   logic [7:0] mem    [0:MAXV-1];
   logic [7:0] golden [0:MAXV-1];
   int phys = 0;
   bit wrap = 1'b1;
   int lat  = 0;
   int wcnt = 0;
   int acc_total = 0;
   int hold_viol = 0;
   logic          p_rd = 1'b0, p_wr = 1'b0, p_rdy = 1'b0;
   logic [AW-1:0] p_addr = '0;
   logic [7:0]    p_wdata = '0;

   assign mem_ready = (mem_rd || mem_wr) && (wcnt >= lat);

   always_comb begin
      if (phys == 0) mem_rdata = 8'hFF;
      else if (wrap) mem_rdata = mem[int'(mem_addr) % phys];
      else if (int'(mem_addr) < phys) mem_rdata = mem[mem_addr];
      else mem_rdata = 8'hFF;
   end

   always @(posedge clk) begin
      if (mem_rd || mem_wr) begin
         if (mem_ready) begin
            wcnt <= 0;
            acc_total <= acc_total + 1;
            if (mem_wr && phys != 0) begin
               if (wrap) mem[int'(mem_addr) % phys] <= mem_wdata;
               else if (int'(mem_addr) < phys) mem[mem_addr] <= mem_wdata;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
      // R2 monitor: pending access must hold
      if ((p_rd || p_wr) && !p_rdy && rst_n) begin
         if (mem_rd != p_rd || mem_wr != p_wr || mem_addr != p_addr ||
             (p_wr && mem_wdata != p_wdata))
            hold_viol <= hold_viol + 1;
      end
      if (mem_rd && mem_wr) hold_viol <= hold_viol + 1;
      p_rd <= mem_rd; p_wr <= mem_wr; p_rdy <= mem_ready;
      p_addr <= mem_addr; p_wdata <= mem_wdata;
   end

   int n_chk = 0;
   int n_bad = 0;
   bit timed_out = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      timed_out = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
   end

   function automatic int lg2(input int v);
      int r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

   function automatic int exp_size(input int p, input bit w);
      if (p == 0) return 0;
      if (w && p == 1) return 0;
      if (p >= MAXV) return MAXV;
      return p;
   endfunction

   function automatic int exp_acc(input int p, input bit w);
      if (exp_size(p, w) == 0) return 6;
      if (p >= MAXV) return 6 + 5 * AW + 1;
      if (w) return 6 + 5 * lg2(p) + 3 + 1;
      return 6 + 5 * lg2(p) + 4 + 1;
   endfunction

   task automatic fill(input int seed);
      @(negedge clk);
      for (int i = 0; i < MAXV; i++) begin
         mem[i]    <= 8'((i * 37 + seed) & 8'hFF);
         golden[i]  = 8'((i * 37 + seed) & 8'hFF);
      end
      @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 40000) begin
         @(negedge clk);
         n++;
      end
   endtask

   // R3 R4 R5 R6 R2: one probe against a given memory
   task automatic run_case(input int p, input bit w, input int l, input int seed,
                           input bit poke, input string tag);
      int acc0, diff;
      int bad_bytes = 0;
      phys = p; wrap = w; lat = l;
      fill(seed);
      acc0 = acc_total;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b0, "R7", {tag, " done falls after start"}, done, 0);
      if (poke) begin
         repeat (17) @(negedge clk);
         start = 1'b1;  // R8: ignored mid-run
         @(negedge clk);
         start = 1'b0;
      end
      wait_done();
      check(done == 1'b1, "R5", {tag, " done reached"}, done, 1);
      check(int'(size) == exp_size(p, w), w ? "R5" : "R3",
            {tag, " size"}, size, exp_size(p, w));
      diff = acc_total - acc0;
      check(diff == exp_acc(p, w), "R4", {tag, " access count"}, diff, exp_acc(p, w));
      for (int i = 0; i < ((p < MAXV) ? p : MAXV); i++)
         if (mem[i] != golden[i]) bad_bytes++;
      check(bad_bytes == 0, "R6", {tag, " bytes restored"}, bad_bytes, 0);
      check(hold_viol == 0, "R2", {tag, " strobe hold"}, hold_viol, 0);
   endtask

   task automatic t_reset();
      check(!done && !mem_rd && !mem_wr, "R1", "reset state",
            {done, mem_rd, mem_wr}, 0);
   endtask

   task automatic t_hold();
      logic [AW:0] s0;
      bit ok = 1'b1;
      s0 = size;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (!done || size != s0 || mem_rd || mem_wr) ok = 1'b0;
      end
      check(ok, "R7", "done and size held", size, s0);
   endtask

   initial begin
      for (int i = 0; i < MAXV; i++) begin
         mem[i] = 8'h00;
         golden[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_case(MAXV, 1'b1, 0, 11, 1'b0, "full");
      t_hold();
      run_case(64,   1'b1, 2, 91, 1'b0, "wrap64");
      run_case(128,  1'b0, 1, 5,  1'b0, "open128");
      run_case(0,    1'b0, 0, 3,  1'b0, "absent");
      run_case(1,    1'b1, 1, 77, 1'b0, "tiny");
      run_case(1,    1'b0, 0, 42, 1'b0, "open1");
      run_case(256,  1'b1, 3, 19, 1'b1, "busystart");
      t_hold();
      if (!timed_out) report();
   end

endmodule